// File: doc/BRIEF.md
# Width-Packing DMA Channel FIFO

This block is the data buffer of one DMA channel. The source side writes a word whose width is picked per write by a 3-bit width code. The destination side reads words of a width picked by its own code. Bytes are stored in order. Narrow writes are packed into wider reads, and wide writes are split into narrower reads, little-endian, so the earliest byte sits in the lowest lane.

The channel is steered by three inputs: enable, suspend and block-done. While suspended, the block takes no new source data. It keeps handing out whole destination words, and it reports empty once the stored bytes can no longer make a whole destination word. If the channel is then disabled, the leftover bytes are thrown away: a one-cycle pulse flags this, and a running total records how many bytes were lost. If the channel is resumed instead, the leftover bytes are kept. Block-done starts a flush that also sends out a final partial word. Received bytes are counted when they are written in, so bytes that are later lost still appear in that count.

Top module: `wpack_fifo`

## Requirements
- R1: A width code c in the range 0 to 4 means 2^c bytes. Stream byte k goes out in byte lane (k mod destination bytes), bits [8*lane+7 : 8*lane] of `dst_data`, in the same order it was written, whatever the two widths are.
- R2: `src_ready` is low while the channel is disabled, suspended or flushing, and while free space (32 bytes minus stored bytes) is less than the source width. The stored byte count never exceeds 32.
- R3: Outside a flush, `dst_valid` is high exactly when the channel is enabled and at least one destination word is stored. `dst_nbytes` then equals the destination width.
- R4: `fifo_empty` is high when no byte is stored if not suspended. While suspended, it is high as soon as the stored bytes are fewer than one destination word, even when that number is non-zero.
- R5: While suspended, whole destination words keep draining, and the bytes that are fewer than one word stay stored.
- R6: Driving `ch_en` low clears all stored bytes on the next clock edge. When bytes were stored, `drop_pulse` is high for exactly one cycle and `drop_count` grows by their number. Those bytes never reach `dst_data`.
- R7: Clearing suspend with the channel still enabled keeps the leftover bytes. They are delivered first, in order, ahead of later writes.
- R8: A `blk_done` pulse starts a flush. The flush sends whole words and then a final word of `dst_nbytes` = remaining bytes, with unused upper lanes zero. Writes are refused until the store is empty.
- R9: `rx_count` grows by the source width on each accepted write, at the clock edge of acceptance. It does not change otherwise, and dropping bytes does not reduce it.
- R10: When source writes always arrive in groups that make whole destination words, a suspend followed by a disable drops nothing, and no drop pulse occurs.
- R11: After reset, nothing is stored, `fifo_empty` is high, `dst_valid` and `drop_pulse` are low, and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_en | input | 1 | Channel enable; low clears the store |
| ch_susp | input | 1 | Suspend: stop accepting source data |
| blk_done | input | 1 | Pulse: block size reached, start flush |
| src_valid | input | 1 | Source write request |
| src_wcode | input | 3 | Source width code, 2^code bytes |
| src_data | input | 128 | Source data, byte lane 0 first |
| src_ready | output | 1 | Source write accepted when high with src_valid |
| dst_wcode | input | 3 | Destination width code, 2^code bytes |
| dst_ready | input | 1 | Destination takes the offered word |
| dst_valid | output | 1 | A destination word is offered |
| dst_data | output | 128 | Destination word, unused lanes zero |
| dst_nbytes | output | 5 | Valid bytes in the offered word |
| fifo_empty | output | 1 | Empty status, see R4 |
| rx_count | output | 16 | Total source bytes accepted |
| drop_pulse | output | 1 | One-cycle pulse when bytes were discarded |
| drop_count | output | 16 | Total bytes discarded |

## Verification
The key corner case is a narrow-to-wide transfer that is suspended with two bytes left over. If the design still reported non-empty here, software waiting on the flag would hang. If it counted the residue only when draining, the received-byte count would fall short. After that, the bench both disables the channel and resumes it. A design that kept the residue across a disable would deliver stale bytes. One that cleared the residue on resume would leave a gap in the stream. The flush check looks for a short final word with zeroed upper lanes. A burst-aligned case shows that suspend-then-disable drops nothing. A full-store case confirms that writes are refused and that nothing is overwritten.

// File: rtl/wpack_pkg.sv
// Shared constants and helpers for the width-packing FIFO.
// Assumes width codes above MAX_CODE are treated as the widest width.
package wpack_pkg;
    localparam int unsigned MAX_CODE  = 4;
    localparam int unsigned MAX_BYTES = 1 << MAX_CODE;
    localparam int unsigned NB_W      = $clog2(MAX_BYTES + 1);
    localparam int unsigned DATA_W    = MAX_BYTES * 8;

    typedef logic [2:0]      wcode_t;
    typedef logic [NB_W-1:0] nbytes_t;

    // Byte count for a width code, clamped to the widest lane set.
    function automatic nbytes_t code_bytes(input wcode_t c);
        if (c > wcode_t'(MAX_CODE))
            return nbytes_t'(MAX_BYTES);
        return nbytes_t'(1) << c;
    endfunction
endpackage

// File: rtl/wpack_store.sv
// Byte-wide circular storage with multi-lane write and read windows.
// Writes wr_n bytes starting at wr_ptr; reads rd_n bytes starting at rd_ptr.
// Assumes DEPTH is a power of two, at least MAX_BYTES. The data array is not reset.
module wpack_store
    import wpack_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  nbytes_t           wr_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_ptr,
    input  nbytes_t           rd_n,
    output logic [DATA_W-1:0] rd_data
);
    logic [7:0] mem [DEPTH];

    // Store the low wr_n source lanes into consecutive byte slots.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int i = 0; i < int'(MAX_BYTES); i++) begin
                if (nbytes_t'(i) < wr_n)
                    mem[wr_ptr + PTR_W'(i)] <= wr_data[8*i +: 8];
            end
        end
    end

    // Present rd_n bytes in ascending lanes, zero above them.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < int'(MAX_BYTES); i++) begin
            if (nbytes_t'(i) < rd_n)
                rd_data[8*i +: 8] = mem[rd_ptr + PTR_W'(i)];
        end
    end
endmodule

// File: rtl/wpack_ctrl.sv
// Channel control: pointers, fill level, suspend/disable/flush rules and counters.
// Empty is redefined under suspend as "no whole destination word"; disable
// discards whatever is stored and accounts it in the drop counter.
module wpack_ctrl
    import wpack_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned CNT_W = 16,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ch_en,
    input  logic             ch_susp,
    input  logic             blk_done,
    input  logic             src_valid,
    input  wcode_t           src_wcode,
    input  logic             dst_ready,
    input  wcode_t           dst_wcode,
    output logic             src_ready,
    output logic             dst_valid,
    output nbytes_t          dst_nbytes,
    output logic             fifo_empty,
    output logic             wr_fire,
    output nbytes_t          wr_n,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [LVL_W-1:0] level,
    output logic             flushing,
    output logic [CNT_W-1:0] rx_count,
    output logic             drop_pulse,
    output logic [CNT_W-1:0] drop_count
);
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [LVL_W-1:0] level_q, level_n, space;
    logic [CNT_W-1:0] rx_q, drop_q;
    logic             flush_q, drop_q1, full_word, rd_fire;
    nbytes_t          src_n, dst_n;

    // Decode widths and free space.
    always_comb begin
        src_n = code_bytes(src_wcode);
        dst_n = code_bytes(dst_wcode);
        space = LVL_W'(DEPTH) - level_q;
    end

    // Handshake and status derived from stored level and channel state.
    always_comb begin
        full_word  = level_q >= LVL_W'(dst_n);
        src_ready  = ch_en && !ch_susp && !flush_q && (space >= LVL_W'(src_n));
        dst_valid  = ch_en && (full_word || (flush_q && level_q != '0));
        dst_nbytes = full_word ? dst_n : nbytes_t'(level_q);
        fifo_empty = ch_susp ? !full_word : (level_q == '0);
        wr_fire    = src_valid && src_ready;
        rd_fire    = dst_valid && dst_ready;
        level_n    = level_q
                   + (wr_fire ? LVL_W'(src_n) : '0)
                   - (rd_fire ? LVL_W'(dst_nbytes) : '0);
    end

    // State update: reset, disable-discard, or normal move of bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            level_q  <= '0;
            flush_q  <= 1'b0;
            rx_q     <= '0;
            drop_q   <= '0;
            drop_q1  <= 1'b0;
        end else if (!ch_en) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            level_q  <= '0;
            flush_q  <= 1'b0;
            drop_q1  <= (level_q != '0);
            drop_q   <= drop_q + CNT_W'(level_q);
        end else begin
            drop_q1 <= 1'b0;
            level_q <= level_n;
            if (wr_fire) begin
                wr_ptr_q <= wr_ptr_q + PTR_W'(src_n);
                rx_q     <= rx_q + CNT_W'(src_n);
            end
            if (rd_fire)
                rd_ptr_q <= rd_ptr_q + PTR_W'(dst_nbytes);
            if (blk_done)
                flush_q <= 1'b1;
            else if (level_n == '0)
                flush_q <= 1'b0;
        end
    end

    assign wr_n       = src_n;
    assign wr_ptr     = wr_ptr_q;
    assign rd_ptr     = rd_ptr_q;
    assign level      = level_q;
    assign flushing   = flush_q;
    assign rx_count   = rx_q;
    assign drop_pulse = drop_q1;
    assign drop_count = drop_q;
endmodule

// File: rtl/wpack_fifo.sv
// Top of the width-packing DMA channel FIFO: joins control and byte storage.
// Assumes DEPTH is a power of two and holds at least one widest word.
module wpack_fifo
    import wpack_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ch_en,
    input  logic              ch_susp,
    input  logic              blk_done,
    input  logic              src_valid,
    input  logic [2:0]        src_wcode,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_ready,
    input  logic [2:0]        dst_wcode,
    input  logic              dst_ready,
    output logic              dst_valid,
    output logic [DATA_W-1:0] dst_data,
    output logic [NB_W-1:0]   dst_nbytes,
    output logic              fifo_empty,
    output logic [CNT_W-1:0]  rx_count,
    output logic              drop_pulse,
    output logic [CNT_W-1:0]  drop_count
);
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned LVL_W = $clog2(DEPTH + 1);

    logic             wr_fire, flushing;
    nbytes_t          wr_n;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [LVL_W-1:0] lvl;

    wpack_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .ch_susp(ch_susp),
        .blk_done(blk_done), .src_valid(src_valid), .src_wcode(src_wcode),
        .dst_ready(dst_ready), .dst_wcode(dst_wcode), .src_ready(src_ready),
        .dst_valid(dst_valid), .dst_nbytes(dst_nbytes), .fifo_empty(fifo_empty),
        .wr_fire(wr_fire), .wr_n(wr_n), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .level(lvl), .flushing(flushing), .rx_count(rx_count),
        .drop_pulse(drop_pulse), .drop_count(drop_count)
    );

    wpack_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .wr_en(wr_fire), .wr_ptr(wr_ptr), .wr_n(wr_n),
        .wr_data(src_data), .rd_ptr(rd_ptr), .rd_n(dst_nbytes),
        .rd_data(dst_data)
    );
endmodule

// File: rtl/wpack_fifo_chk.sv
// Property checker for wpack_fifo, attached by bind below.
module wpack_fifo_chk
    import wpack_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned CNT_W = 16,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ch_en,
    input logic             ch_susp,
    input logic             src_valid,
    input logic             src_ready,
    input logic [2:0]       dst_wcode,
    input logic             dst_valid,
    input logic [NB_W-1:0]  dst_nbytes,
    input logic             fifo_empty,
    input logic [LVL_W-1:0] fill,
    input logic             flushing,
    input logic [CNT_W-1:0] rx_count,
    input logic             drop_pulse,
    input logic [CNT_W-1:0] drop_count
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= LVL_W'(DEPTH)); // R2
    AST_NO_WRITE_SUSPENDED: assert property (@(posedge clk) disable iff (!rst_n)
        ch_susp |-> !src_ready); // R2
    AST_WORD_HAS_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
        dst_valid |-> dst_nbytes != '0); // R3
    AST_EMPTY_NO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en && ch_susp && !flushing && fifo_empty) |-> !dst_valid); // R4
    AST_SUSP_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en && ch_susp && !fifo_empty) |-> dst_valid); // R5
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_en |=> fill == '0); // R6
    AST_DROP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        drop_pulse |=> !drop_pulse); // R6
    AST_PARTIAL_IN_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_valid && dst_nbytes < code_bytes(dst_wcode)) |-> flushing); // R8
    AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(src_valid && src_ready) |=> $stable(rx_count)); // R9
endmodule

bind wpack_fifo wpack_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .ch_susp(ch_susp),
    .src_valid(src_valid), .src_ready(src_ready), .dst_wcode(dst_wcode),
    .dst_valid(dst_valid), .dst_nbytes(dst_nbytes), .fifo_empty(fifo_empty),
    .fill(lvl), .flushing(flushing), .rx_count(rx_count),
    .drop_pulse(drop_pulse), .drop_count(drop_count)
);

// File: tb/wpack_fifo_bench.sv
module wpack_fifo_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ch_en = 1'b0, ch_susp = 1'b0, blk_done = 1'b0;
    logic         src_valid = 1'b0, dst_ready = 1'b0;
    logic [2:0]   src_wcode = '0, dst_wcode = '0;
    logic [127:0] src_data = '0;
    logic         src_ready, dst_valid, fifo_empty, drop_pulse;
    logic [127:0] dst_data;
    logic [4:0]   dst_nbytes;
    logic [15:0]  rx_count, drop_count;

    int n_chk = 0, n_err = 0, wr_seq = 0, rd_seq = 0;
    logic [15:0] rx_ref, drop_ref;

    always #5 clk = ~clk;

    wpack_fifo u_wpack_fifo (
        .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .ch_susp(ch_susp),
        .blk_done(blk_done), .src_valid(src_valid), .src_wcode(src_wcode),
        .src_data(src_data), .src_ready(src_ready), .dst_wcode(dst_wcode),
        .dst_ready(dst_ready), .dst_valid(dst_valid), .dst_data(dst_data),
        .dst_nbytes(dst_nbytes), .fifo_empty(fifo_empty), .rx_count(rx_count),
        .drop_pulse(drop_pulse), .drop_count(drop_count)
    );

    // Vector: src code, dst code, total bytes (multiple of both widths).
    localparam logic [11:0] VEC [7] = '{
        {3'd0, 3'd2, 6'd16}, {3'd2, 3'd0, 6'd8},  {3'd1, 3'd3, 6'd16},
        {3'd4, 3'd2, 6'd32}, {3'd3, 3'd4, 6'd32}, {3'd0, 3'd0, 6'd4},
        {3'd2, 3'd2, 6'd12}
    };

    function automatic logic [7:0] pat(input int k);
        return 8'(k * 7 + 3);
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic push(input logic [2:0] c, input string req);
        int n = 1 << c;
        src_wcode = c;
        for (int i = 0; i < 16; i++)
            src_data[8*i +: 8] = (i < n) ? pat(wr_seq + i) : 8'h00;
        src_valid = 1'b1;
        #1;
        check(src_ready == 1'b1, req, 128'(src_ready), 128'd1);
        @(posedge clk); @(negedge clk);
        src_valid = 1'b0;
        wr_seq += n;
        rx_ref += 16'(n);
    endtask

    task automatic pop(input logic [2:0] c, input int nexp, input string req);
        logic [127:0] exp = '0;
        dst_wcode = c;
        dst_ready = 1'b1;
        #1;
        for (int i = 0; i < nexp; i++)
            exp[8*i +: 8] = pat(rd_seq + i);
        check(dst_valid == 1'b1, req, 128'(dst_valid), 128'd1);
        check(dst_nbytes == 5'(nexp), req, 128'(dst_nbytes), 128'(nexp));
        check(dst_data == exp, req, dst_data, exp);
        @(posedge clk); @(negedge clk);
        dst_ready = 1'b0;
        rd_seq += nexp;
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rx_ref = '0; drop_ref = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11 reset state
        check(fifo_empty == 1'b1, "R11 empty", 128'(fifo_empty), 128'd1);
        check(dst_valid == 1'b0, "R11 dst_valid", 128'(dst_valid), 128'd0);
        check(drop_pulse == 1'b0, "R11 drop_pulse", 128'(drop_pulse), 128'd0);
        check(rx_count == 16'd0 && drop_count == 16'd0, "R11 counters",
              128'({rx_count, drop_count}), 128'd0);
        check(src_ready == 1'b0, "R2 disabled", 128'(src_ready), 128'd0);
        @(negedge clk);
        ch_en = 1'b1;

        // R1 packing table walk
        for (int v = 0; v < 7; v++) begin
            logic [2:0] sc = VEC[v][11:9];
            logic [2:0] dc = VEC[v][8:6];
            int tot = int'(VEC[v][5:0]);
            for (int k = 0; k < tot / (1 << sc); k++) push(sc, "R1 write");
            check(rx_count == rx_ref, "R9 rx_count", 128'(rx_count), 128'(rx_ref));
            for (int k = 0; k < tot / (1 << dc); k++) pop(dc, 1 << dc, "R1 pack");
            #1;
            check(fifo_empty == 1'b1, "R4 empty after drain", 128'(fifo_empty), 128'd1);
        end

        // R2 full store refuses further writes
        push(3'd4, "R2 fill"); push(3'd4, "R2 fill");
        src_wcode = 3'd0; #1;
        check(src_ready == 1'b0, "R2 full", 128'(src_ready), 128'd0);
        pop(3'd4, 16, "R2 drain"); pop(3'd4, 16, "R2 drain");

        // R4 R5 R6 R9 suspend then disable with residue
        for (int k = 0; k < 6; k++) push(3'd0, "R9 write");
        dst_wcode = 3'd2; ch_susp = 1'b1; #1;
        check(src_ready == 1'b0, "R2 suspended", 128'(src_ready), 128'd0);
        check(fifo_empty == 1'b0, "R5 word pending", 128'(fifo_empty), 128'd0);
        pop(3'd2, 4, "R5 drain in suspend");
        #1;
        check(fifo_empty == 1'b1, "R4 residue empty", 128'(fifo_empty), 128'd1);
        check(dst_valid == 1'b0, "R5 residue held", 128'(dst_valid), 128'd0);
        ch_en = 1'b0;
        @(posedge clk); @(negedge clk); #1;
        drop_ref += 16'd2;
        check(drop_pulse == 1'b1, "R6 drop pulse", 128'(drop_pulse), 128'd1);
        check(drop_count == drop_ref, "R6 drop count", 128'(drop_count), 128'(drop_ref));
        check(rx_count == rx_ref, "R9 rx keeps dropped", 128'(rx_count), 128'(rx_ref));
        ch_en = 1'b1; ch_susp = 1'b0; rd_seq = wr_seq;
        @(posedge clk); @(negedge clk); #1;
        check(drop_pulse == 1'b0, "R6 pulse one cycle", 128'(drop_pulse), 128'd0);
        check(fifo_empty == 1'b1 && dst_valid == 1'b0, "R6 residue gone",
              128'({fifo_empty, dst_valid}), 128'b10);

        // R7 suspend then resume keeps residue
        for (int k = 0; k < 6; k++) push(3'd0, "R7 write");
        ch_susp = 1'b1;
        pop(3'd2, 4, "R7 drain in suspend");
        #1;
        check(fifo_empty == 1'b1, "R4 suspended residue", 128'(fifo_empty), 128'd1);
        ch_susp = 1'b0; #1;
        check(fifo_empty == 1'b0, "R7 residue kept", 128'(fifo_empty), 128'd0);
        push(3'd1, "R7 write more");
        pop(3'd2, 4, "R7 residue order");
        check(drop_count == drop_ref, "R7 no drop", 128'(drop_count), 128'(drop_ref));

        // R8 flush of a partial word
        for (int k = 0; k < 6; k++) push(3'd0, "R8 write");
        pop(3'd2, 4, "R8 full word");
        blk_done = 1'b1;
        @(posedge clk); @(negedge clk);
        blk_done = 1'b0; #1;
        check(src_ready == 1'b0, "R8 writes held", 128'(src_ready), 128'd0);
        pop(3'd2, 2, "R8 partial word");
        #1;
        check(src_ready == 1'b1 && fifo_empty == 1'b1, "R8 flush ends",
              128'({src_ready, fifo_empty}), 128'b11);

        // R10 burst-aligned source leaves nothing behind
        for (int k = 0; k < 4; k++) push(3'd1, "R10 write");
        ch_susp = 1'b1;
        pop(3'd2, 4, "R10 drain"); pop(3'd2, 4, "R10 drain");
        ch_en = 1'b0;
        @(posedge clk); @(negedge clk); #1;
        check(drop_pulse == 1'b0, "R10 no pulse", 128'(drop_pulse), 128'd0);
        check(drop_count == drop_ref, "R10 no loss", 128'(drop_count), 128'(drop_ref));
        check(rx_count == rx_ref, "R9 total", 128'(rx_count), 128'(rx_ref));

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule